// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only line cache made of two parts. The first is a direct-mapped array in which every line address has exactly one home slot. The second is a small fully-associative buffer that keeps the lines pushed out of that array. A requester presents one line address at a time. If the direct-mapped slot holds the line, the data comes back on the next cycle. If the slot holds some other line but the buffer holds the requested one, the two lines trade places in a single cycle and the data still comes back on the next cycle. If neither part holds the line, the displaced line moves into the buffer, a fetch goes to the next memory level, and the returned line lands in the direct-mapped slot.

A line is never held in both parts at once, so the buffer adds capacity that is used exactly where address conflicts would otherwise cause repeated off-chip fetches. The buffer replaces its least-recently-written entry, and it fills empty entries first. While a fetch is outstanding the block is busy: it takes no new requests.

Top module: `vc_cache_top`

## Requirements
- R1: After reset the block is idle (`busy`, `resp_valid` and `mem_req_valid` low) and holds no lines, so the first access to any address issues a fetch.
- R2: The direct-mapped slot of an address is its low IDX_W bits and the stored tag is its remaining upper bits; two addresses that share the low bits displace each other.
- R3: A request that hits the direct-mapped array raises `resp_valid` with that line's data on the cycle after the request, and issues no fetch.
- R4: A request that misses the direct-mapped array but hits the victim buffer swaps the two lines, raises `resp_valid` with the requested data on the cycle after the request, and issues no fetch; the line it displaced then hits without a fetch.
- R5: A line is held in at most one of the two structures. The buffer receives only lines leaving the direct-mapped array, and a fetched line is written only into the direct-mapped array.
- R6: On a miss in both structures, `mem_req_valid` rises on the cycle after the request with `mem_req_addr` equal to the requested address. Both stay unchanged, and `busy` stays high, until `mem_rsp_valid` is seen.
- R7: When `mem_rsp_valid` is high during a fetch, `mem_rsp_data` is written into the direct-mapped slot, and on the next cycle `resp_valid` pulses with that data while `busy` and `mem_req_valid` drop.
- R8: The victim buffer fills an empty entry first; when it is full, the entry written least recently is replaced. As a result, cycling through 5 addresses of one slot hits after warm-up, and cycling through 6 misses on every access.
- R9: A request made while `busy` is high has no effect, and `mem_rsp_valid` has no effect while no fetch is outstanding.
- R10: Each victim entry matches on the whole line address, so lines from different direct-mapped slots held in the buffer together are told apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request, taken when `busy` is low |
| req_addr | input | ADDR_W | Line address of the request |
| busy | output | 1 | A fetch is outstanding; requests are ignored |
| resp_valid | output | 1 | One-cycle pulse: `resp_data` holds the requested line |
| resp_data | output | DATA_W | Returned line data |
| mem_req_valid | output | 1 | Fetch request to the next level, held until answered |
| mem_req_addr | output | ADDR_W | Line address being fetched |
| mem_rsp_valid | input | 1 | Fetched line is present on `mem_rsp_data` |
| mem_rsp_data | input | DATA_W | Fetched line data |

## Verification
A corrupted tag, valid bit or recency age does not show up at once. It shows up at the next access to the affected address: an access that should hit raises `mem_req_valid` instead of `resp_valid`, an access that should miss answers without a fetch, or the response comes back one cycle after the request with another line's data. Because every line's data is a fixed arithmetic function of its address, a swap that moves data into the wrong place is caught on the first later hit to either line. Replacement-order faults appear within one round of a same-slot cycling pattern, as the miss count moving away from zero or from all-misses.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } vc_state_e;
endpackage

// File: rtl/vc_dm_array.sv
module vc_dm_array #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q <= valid_d;
  end

  // Tag and data arrays carry no reset: the valid bit qualifies them.
  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [PTR_W-1:0] touch_ptr,
  input  logic [DEPTH-1:0] valid_vec,
  output logic [PTR_W-1:0] victim_ptr
);
  // Ages form a permutation of 0..DEPTH-1; 0 is newest. DEPTH must be a power of two.
  logic [PTR_W-1:0] age_q [DEPTH];
  logic [PTR_W-1:0] age_d [DEPTH];
  logic [DEPTH-1:0] oldest_vec;
  logic [PTR_W-1:0] oldest_ptr, empty_ptr;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (PTR_W'(i) == touch_ptr)          age_d[i] = '0;
        else if (age_q[i] < age_q[touch_ptr]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= PTR_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_d[i];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_oldest
      assign oldest_vec[g] = (age_q[g] == PTR_W'(DEPTH - 1));
    end
  endgenerate

  always_comb begin
    oldest_ptr = '0;
    empty_ptr  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (oldest_vec[i])  oldest_ptr = PTR_W'(i);
      if (!valid_vec[i])  empty_ptr  = PTR_W'(i);
    end
    victim_ptr = (&valid_vec) ? oldest_ptr : empty_ptr;
  end

  // R8: exactly one entry is the replacement candidate by age
  assert_single_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
  // R8: a touched entry becomes newest
  assert_touch_newest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_ptr)] == '0);
endmodule

// File: rtl/vc_victim_store.sv
module vc_victim_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              wr_en,
  input  logic              wr_at_hit,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DEPTH-1:0]  valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  match_vec;
  logic [PTR_W-1:0]  hit_ptr, repl_ptr, wr_ptr;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (addr_q[g] == look_addr);
    end
  endgenerate

  always_comb begin
    hit_ptr = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match_vec[i]) hit_ptr = PTR_W'(i);
  end

  assign hit      = |match_vec;
  assign hit_data = data_q[hit_ptr];
  assign wr_ptr   = wr_at_hit ? hit_ptr : repl_ptr;

  vc_lru #(.DEPTH(DEPTH)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (wr_en),
    .touch_ptr  (wr_ptr),
    .valid_vec  (valid_q),
    .victim_ptr (repl_ptr)
  );

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_ptr] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_valid) begin
      addr_q[wr_ptr] <= wr_addr;
      data_q[wr_ptr] <= wr_data;
    end
  end

  // R5/R10: an address is held by at most one entry
  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  // R8: a swap never targets an entry that did not match
  assert_swap_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_at_hit) |-> hit);
endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top #(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 2,
  parameter int DATA_W   = 16,
  parameter int VC_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  import vc_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  vc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] pend_q, pend_d;
  logic              resp_v_q, resp_v_d;
  logic [DATA_W-1:0] resp_d_q, resp_d_d;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              accept, dm_hit;
  logic              dm_rd_valid;
  logic [TAG_W-1:0]  dm_rd_tag;
  logic [DATA_W-1:0] dm_rd_data;
  logic              dm_wr_en, dm_wr_valid;
  logic [IDX_W-1:0]  dm_wr_idx;
  logic [TAG_W-1:0]  dm_wr_tag;
  logic [DATA_W-1:0] dm_wr_data;
  logic              vc_hit;
  logic [DATA_W-1:0] vc_hit_data;
  logic              vc_wr_en, vc_wr_at_hit;

  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign dm_hit  = dm_rd_valid && (dm_rd_tag == req_tag);

  vc_dm_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .rd_idx   (req_idx),
    .rd_valid (dm_rd_valid),
    .rd_tag   (dm_rd_tag),
    .rd_data  (dm_rd_data),
    .wr_en    (dm_wr_en),
    .wr_idx   (dm_wr_idx),
    .wr_valid (dm_wr_valid),
    .wr_tag   (dm_wr_tag),
    .wr_data  (dm_wr_data)
  );

  // The displaced line always carries the direct-mapped line's own address.
  vc_victim_store #(.DEPTH(VC_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vc (
    .clk       (clk),
    .rst_n     (rst_ni),
    .look_addr (req_addr),
    .hit       (vc_hit),
    .hit_data  (vc_hit_data),
    .wr_en     (vc_wr_en),
    .wr_at_hit (vc_wr_at_hit),
    .wr_valid  (dm_rd_valid),
    .wr_addr   ({dm_rd_tag, req_idx}),
    .wr_data   (dm_rd_data)
  );

  always_comb begin
    state_d      = state_q;
    pend_d       = pend_q;
    resp_v_d     = 1'b0;
    resp_d_d     = resp_d_q;
    dm_wr_en     = 1'b0;
    dm_wr_idx    = req_idx;
    dm_wr_valid  = 1'b0;
    dm_wr_tag    = req_tag;
    dm_wr_data   = vc_hit_data;
    vc_wr_en     = 1'b0;
    vc_wr_at_hit = 1'b0;
    if (accept) begin
      if (dm_hit) begin
        resp_v_d = 1'b1;
        resp_d_d = dm_rd_data;
      end else if (vc_hit) begin
        // exchange: buffer line into the slot, slot line into that entry
        dm_wr_en     = 1'b1;
        dm_wr_valid  = 1'b1;
        vc_wr_en     = 1'b1;
        vc_wr_at_hit = 1'b1;
        resp_v_d     = 1'b1;
        resp_d_d     = vc_hit_data;
      end else begin
        // both miss: park the displaced line, free the slot, fetch
        dm_wr_en = 1'b1;
        vc_wr_en = dm_rd_valid;
        pend_d   = req_addr;
        state_d  = ST_FILL;
      end
    end
    if (state_q == ST_FILL && mem_rsp_valid) begin
      dm_wr_en    = 1'b1;
      dm_wr_idx   = pend_q[IDX_W-1:0];
      dm_wr_valid = 1'b1;
      dm_wr_tag   = pend_q[ADDR_W-1:IDX_W];
      dm_wr_data  = mem_rsp_data;
      resp_v_d    = 1'b1;
      resp_d_d    = mem_rsp_data;
      state_d     = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      resp_v_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      resp_v_q <= resp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) pend_q <= pend_d;
    if (resp_v_d) resp_d_q <= resp_d_d;
  end

  assign busy          = (state_q == ST_FILL);
  assign mem_req_valid = (state_q == ST_FILL);
  assign mem_req_addr  = pend_q;
  assign resp_valid    = resp_v_q;
  assign resp_data     = resp_d_q;

  // R5: a line is never present in both structures
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |-> !(dm_hit && vc_hit));
  // R3: a direct-mapped hit answers next cycle with the slot data
  assert_dm_hit_resp_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && dm_hit) |=> resp_valid && !mem_req_valid && resp_data == $past(dm_rd_data));
  // R4: a buffer hit answers next cycle without a fetch
  assert_vc_hit_resp_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !dm_hit && vc_hit) |=> resp_valid && !mem_req_valid);
  // R6: a double miss starts a fetch for the requested address
  assert_miss_fetch_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !dm_hit && !vc_hit) |=> mem_req_valid && !resp_valid && mem_req_addr == $past(req_addr));
  // R6: an unanswered fetch is held steady
  assert_fetch_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req_valid && !mem_rsp_valid) |=> mem_req_valid && $stable(mem_req_addr));
  // R7: an answer ends the fetch and returns the data
  assert_refill_resp_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req_valid && mem_rsp_valid) |=> resp_valid && !busy && resp_data == $past(mem_rsp_data));
  // R9: an idle response strobe produces nothing
  assert_idle_rsp_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && !req_valid) |=> !resp_valid && !mem_req_valid);
endmodule

// File: tb/vc_cache_top_test.sv
`timescale 1ns/1ps
module vc_cache_top_test;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;
  localparam int VD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, resp_valid, mem_req_valid;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vc_cache_top #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW), .VC_DEPTH(VD)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .busy          (busy),
    .resp_valid    (resp_valid),
    .resp_data     (resp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  // Memory contents: a fixed function of the line address.
  function automatic logic [DW-1:0] line_of(input int a);
    return DW'((a * 40503 + 7) ^ (a << 5));
  endfunction

  // Reference: one home slot per index plus a recency list of parked lines.
  bit dm_v [4];
  int dm_a [4];
  int lst  [5];
  int cnt;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin dm_v[i] = 0; dm_a[i] = 0; end
    cnt = 0;
  endtask

  // kind: 0 slot hit, 1 buffer hit, 2 miss
  task automatic model_access(input int a, output int kind);
    int idx;
    int p;
    idx = a % 4;
    p = -1;
    kind = 2;
    if (dm_v[idx] && dm_a[idx] == a) begin
      kind = 0;
    end else begin
      for (int k = 0; k < cnt; k++) if (lst[k] == a) p = k;
      if (p >= 0) begin
        kind = 1;
        for (int k = p; k < cnt - 1; k++) lst[k] = lst[k + 1];
        cnt--;
      end
      if (dm_v[idx]) begin
        for (int k = 4; k > 0; k--) lst[k] = lst[k - 1];
        lst[0] = dm_a[idx];
        if (cnt < 4) cnt++;
      end
      dm_v[idx] = 1;
      dm_a[idx] = a;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One access; returns 1 if a fetch was observed. ign_busy injects a request while busy.
  task automatic do_access(input int a, input int lat, input bit ign_busy,
                           input string req, output bit missed);
    int kind;
    int exp_pack;
    int act_pack;
    model_access(a, kind);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    missed = mem_req_valid;
    if (kind != 2) begin
      exp_pack = {1'b1, 1'b0, 1'b0, 16'(line_of(a))};
      act_pack = {resp_valid, mem_req_valid, busy, resp_data};
      check(act_pack == exp_pack, (kind == 0) ? {req, "/R3"} : {req, "/R4"},
            $sformatf("hit addr %0d {rv,mrv,busy,data}", a), act_pack, exp_pack);
    end else begin
      exp_pack = {1'b0, 1'b1, 1'b1, 8'(a)};
      act_pack = {resp_valid, mem_req_valid, busy, mem_req_addr};
      check(act_pack == exp_pack, {req, "/R6"},
            $sformatf("miss addr %0d {rv,mrv,busy,maddr}", a), act_pack, exp_pack);
      for (int w = 0; w < lat; w++) begin
        if (ign_busy && w == 0) begin
          req_valid = 1'b1;
          req_addr  = AW'(a ^ 8'h01);
        end
        @(negedge clk);
        req_valid = 1'b0;
        act_pack = {resp_valid, mem_req_valid, busy, mem_req_addr};
        check(act_pack == exp_pack, ign_busy ? "R9" : "R6",
              $sformatf("fetch held addr %0d", a), act_pack, exp_pack);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = line_of(a);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      exp_pack = {1'b1, 1'b0, 1'b0, 16'(line_of(a))};
      act_pack = {resp_valid, mem_req_valid, busy, resp_data};
      check(act_pack == exp_pack, "R7",
            $sformatf("refill addr %0d {rv,mrv,busy,data}", a), act_pack, exp_pack);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit m;
    int misses;
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: idle outputs during and after reset
    check({busy, resp_valid, mem_req_valid} == 3'b000, "R1", "outputs in reset",
          {busy, resp_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, resp_valid, mem_req_valid} == 3'b000, "R1", "outputs after reset",
          {busy, resp_valid, mem_req_valid}, 0);
    do_access(0, 1, 0, "R1", m);
    check(m == 1'b1, "R1", "first access fetches", m, 1);

    // R9: response strobe while idle
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = 16'hDEAD;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check({resp_valid, busy, mem_req_valid} == 3'b000, "R9", "idle strobe ignored",
          {resp_valid, busy, mem_req_valid}, 0);
    do_access(0, 0, 0, "R9", m);
    check(m == 1'b0, "R9", "line intact after idle strobe", m, 0);

    // R2: 9 and 13 share slot 1; 9 and 10 do not conflict
    do_access(9, 0, 0, "R2", m);
    do_access(10, 0, 0, "R2", m);
    do_access(13, 2, 0, "R2", m);
    check(m == 1'b1, "R2", "13 displaces 9", m, 1);
    do_access(10, 0, 0, "R2", m);
    check(m == 1'b0, "R2", "10 kept in other slot", m, 0);
    // R4: swap back and forth without fetches
    do_access(9, 0, 0, "R4", m);
    check(m == 1'b0, "R4", "9 from buffer", m, 0);
    do_access(13, 0, 0, "R4", m);
    check(m == 1'b0, "R4", "13 after swap", m, 0);

    // R10: buffer entries from different slots told apart
    do_access(4, 1, 0, "R10", m);
    do_access(1, 1, 0, "R10", m);
    do_access(0, 0, 0, "R10", m);
    check(m == 1'b0, "R10", "0 found among mixed entries", m, 0);

    // R9: request while busy has no effect
    do_access(66, 3, 1, "R9", m);
    do_access(67, 1, 0, "R9", m);
    check(m == 1'b1, "R9", "busy-time request not installed", m, 1);

    // R8: 5 same-slot lines fit, 6 thrash under least-recent replacement
    for (int n = 5; n <= 6; n++) begin
      for (int r = 0; r < 3; r++) begin
        misses = 0;
        for (int k = 0; k < n; k++) begin
          do_access(128 + 4 * k + 2, k % 3, 0, "R8", m);
          misses += int'(m);
        end
        if (r == 2)
          check(misses == ((n == 5) ? 0 : n), "R8",
                $sformatf("misses per round, %0d lines", n), misses, (n == 5) ? 0 : n);
      end
    end

    // R5: sweep every line address twice, then pseudo-random traffic
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 256; a++) do_access(p ? 255 - a : a, a % 3, a % 7 == 0, "R5", m);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_access(lfsr[6] ? int'(lfsr[5:0]) : int'(lfsr[3:0]) % 12, int'(lfsr[9:8]),
                lfsr[11], "R5", m);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule